// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is a 16-bit timer that counts up from zero to a programmable ceiling and then back down to zero. It drives one waveform output from a compare value. Because every period is one full up-and-down sweep, the output pulses stay centred on the counter's zero point. Whether a compare match sets or clears the output depends on the slope the counter is on. This gives symmetric PWM whose frequency is the clock divided by 2·N·TOP, where N is the prescale factor.

The host writes the ceiling (TOP) and the compare value into shadow registers. The counter copies both into its working registers only on the tick that leaves zero, so a period is never cut short or made lopsided. A mode write takes effect at once and selects one of four output actions:

| Code | Action |
|------|--------|
| 0 | disconnected |
| 1 | toggle |
| 2 | non-inverted |
| 3 | inverted |

The mode word has one more bit that makes the compare value serve as TOP, which turns the toggle action into a 50 % square wave. A sticky match flag reports compare hits until the host clears it.

Top module: `pfc_pwm_timer`

## Requirements
- R1: After reset, `count` is 0, and `count_down`, `pwm_out` and `match_flag` are low.
- R2: `clk_sel` sets the prescale factor N: 1→1, 2→8, 3→64, 4→256, 5→1024. Codes 0, 6 and 7 stop the counter, and `count` then holds its value.
- R3: On each tick the counter steps by one, rising from 0 to TOP and then falling back. Each extreme lasts one tick, so a period is 2·TOP ticks. `count_down` is high from the cycle after the counter leaves TOP until the counter leaves 0.
- R4: A write to TOP or to the compare value is held in a shadow register. It reaches the working register only on the tick on which `count` leaves 0.
- R5: Non-inverted (mode word bits [1:0] = 2): a match on the rising slope (count 0 included) drives the output low, and a match on the falling slope (count TOP included) drives it high. The period is 2·N·TOP cycles and the high time is 2·N·C for 0 < C < TOP.
- R6: Inverted (bits [1:0] = 3) takes the opposite actions. The high time is 2·N·(TOP−C).
- R7: In non-inverted mode, C = 0 keeps `pwm_out` constantly low and C = TOP keeps it constantly high. Inverted mode gives the opposite levels.
- R8: Toggle (bits [1:0] = 1) with mode bit [2] = 1 uses the compare value as TOP. The output inverts at each match, giving a square wave with period 4·N·C and high time 2·N·C.
- R9: Disconnected (bits [1:0] = 0) keeps `pwm_out` low.
- R10: `match_flag` rises at the clock edge that ends a tick on which `count` equals the working compare value. It stays high until a cycle with `flag_clr` high and no new match, after which it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock for all logic |
| rst_n | input | 1 | asynchronous active-low reset |
| clk_sel | input | 3 | prescale select |
| top_we | input | 1 | write `wdata` into the TOP shadow register |
| cmp_we | input | 1 | write `wdata` into the compare shadow register |
| mode_we | input | 1 | write `wdata[2:0]` into the mode register |
| wdata | input | 16 | write data |
| flag_clr | input | 1 | clear the match flag |
| pwm_out | output | 1 | waveform output |
| match_flag | output | 1 | sticky compare-match flag |
| count | output | 16 | current counter value |
| count_down | output | 1 | counter is on the falling slope |

## Verification
The assertions assume the host never sets TOP to zero while the counter is running, and never writes a compare value above TOP except where a silent output is intended. The stepping and range properties depend on TOP being at least one whenever the counter is away from zero. Random stimulus draws TOP from 3 to 12 and the compare value from 1 to TOP−1. It uses only the prescale factors 1, 8 and 64, and directed cases cover the extreme compare values and the larger dividers. Every write is made on a falling clock edge, so it never lands in the same cycle as a check.

// File: rtl/pfc_pwm_pkg.sv
package pfc_pwm_pkg;

   localparam int PRESC_W = 10;

   typedef enum logic [1:0] {
      ACT_OFF    = 2'd0,
      ACT_TOGGLE = 2'd1,
      ACT_NONINV = 2'd2,
      ACT_INV    = 2'd3
   } oc_act_e;

   function automatic logic [PRESC_W-1:0] tap_mask(input logic [2:0] s);
      case (s)
         3'd2:    tap_mask = PRESC_W'(10'h007);
         3'd3:    tap_mask = PRESC_W'(10'h03F);
         3'd4:    tap_mask = PRESC_W'(10'h0FF);
         3'd5:    tap_mask = PRESC_W'(10'h3FF);
         default: tap_mask = '0;
      endcase
   endfunction

endpackage

// File: rtl/pfc_pwm_prescaler.sv
module pfc_pwm_prescaler #(
   parameter bit USE_DIV = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   output logic       tick
);
   import pfc_pwm_pkg::*;

   logic sel_on;
   assign sel_on = (sel >= 3'd1) && (sel <= 3'd5);

   generate
      if (USE_DIV) begin : g_div
         logic [PRESC_W-1:0] pre_q;
         logic [PRESC_W-1:0] mask;
         assign mask = tap_mask(sel);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pre_q <= '0;
            else if (sel_on) pre_q <= pre_q + 1'b1;
            else             pre_q <= '0;
         end
         assign tick = sel_on && ((pre_q & mask) == mask);
      end else begin : g_nodiv
         assign tick = sel_on;
      end
   endgenerate
endmodule

// File: rtl/pfc_pwm_counter.sv
module pfc_pwm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             top_we,
   input  logic             cmp_we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             top_from_cmp,
   output logic [CNT_W-1:0] count,
   output logic             count_down,
   output logic [CNT_W-1:0] top_act,
   output logic             hit,
   output logic             slope_down
);
   logic [CNT_W-1:0] cnt_q, top_buf, cmp_buf, top_q, cmp_q;
   logic [CNT_W-1:0] top_nxt, top_cur, cmp_cur;
   logic             dir_q, at_bottom;

   assign at_bottom  = (cnt_q == '0);
   assign top_nxt    = top_from_cmp ? cmp_buf : top_buf;
   assign top_cur    = at_bottom ? top_nxt : top_q;
   assign cmp_cur    = at_bottom ? cmp_buf : cmp_q;
   assign hit        = tick && (cnt_q == cmp_cur);
   assign slope_down = !at_bottom && (dir_q || (cnt_q == top_cur));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_buf <= '0;
         cmp_buf <= '0;
      end else begin
         if (top_we) top_buf <= wdata;
         if (cmp_we) cmp_buf <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
         top_q <= '0;
         cmp_q <= '0;
      end else if (tick) begin
         if (at_bottom) begin
            top_q <= top_nxt;
            cmp_q <= cmp_buf;
            dir_q <= 1'b0;
            cnt_q <= (top_nxt != '0) ? CNT_W'(1) : '0;
         end else if (cnt_q == top_q) begin
            dir_q <= 1'b1;
            cnt_q <= cnt_q - 1'b1;
         end else if (dir_q) begin
            cnt_q <= cnt_q - 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign count      = cnt_q;
   assign count_down = dir_q;
   assign top_act    = top_q;
endmodule

// File: rtl/pfc_pwm_outunit.sv
module pfc_pwm_outunit (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hit,
   input  logic                 slope_down,
   input  pfc_pwm_pkg::oc_act_e act,
   input  logic                 flag_clr,
   output logic                 oc_q,
   output logic                 pwm_out,
   output logic                 match_flag
);
   import pfc_pwm_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_q <= 1'b0;
      end else if (hit) begin
         case (act)
            ACT_TOGGLE: oc_q <= ~oc_q;
            ACT_NONINV: oc_q <= slope_down;
            ACT_INV:    oc_q <= ~slope_down;
            default:    oc_q <= oc_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        match_flag <= 1'b0;
      else if (hit)      match_flag <= 1'b1;
      else if (flag_clr) match_flag <= 1'b0;
   end

   assign pwm_out = (act == ACT_OFF) ? 1'b0 : oc_q;
endmodule

// File: rtl/pfc_pwm_timer.sv
module pfc_pwm_timer #(
   parameter int CNT_W   = 16,
   parameter bit USE_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       clk_sel,
   input  logic             top_we,
   input  logic             cmp_we,
   input  logic             mode_we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             flag_clr,
   output logic             pwm_out,
   output logic             match_flag,
   output logic [CNT_W-1:0] count,
   output logic             count_down
);
   import pfc_pwm_pkg::*;

   localparam int MODE_W = 3;

   generate
      if (CNT_W < MODE_W || CNT_W > 32) begin : g_bad_width
         $error("pfc_pwm_timer: CNT_W must lie in 3..32");
      end
   endgenerate

   logic             tick, hit, slope_down, oc_q, top_src_q;
   logic [CNT_W-1:0] top_act;
   oc_act_e          act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= ACT_OFF;
         top_src_q <= 1'b0;
      end else if (mode_we) begin
         act_q     <= oc_act_e'(wdata[1:0]);
         top_src_q <= wdata[2];
      end
   end

   pfc_pwm_prescaler #(.USE_DIV(USE_DIV)) i_presc (
      .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
   );

   pfc_pwm_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .top_we(top_we), .cmp_we(cmp_we), .wdata(wdata),
      .top_from_cmp(top_src_q),
      .count(count), .count_down(count_down), .top_act(top_act),
      .hit(hit), .slope_down(slope_down)
   );

   pfc_pwm_outunit i_out (
      .clk(clk), .rst_n(rst_n), .hit(hit), .slope_down(slope_down),
      .act(act_q), .flag_clr(flag_clr),
      .oc_q(oc_q), .pwm_out(pwm_out), .match_flag(match_flag)
   );
endmodule

// File: rtl/pfc_pwm_checks.sv
module pfc_pwm_checks #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             hit,
   input logic             flag_clr,
   input logic             match_flag,
   input logic             oc_q,
   input logic             count_down,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] top_act
);
   a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count != '0) |=>
         (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1));

   a_r3_within_top: assert property (@(posedge clk) disable iff (!rst_n)
      count <= top_act);

   a_r3_turn_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == top_act && count != '0) |=> count_down);

   a_r5_out_moves_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(oc_q));

   a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> match_flag);

   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag && !flag_clr) |=> match_flag);

   a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !hit) |=> !match_flag);
endmodule

bind pfc_pwm_timer pfc_pwm_checks #(.CNT_W(CNT_W)) i_checks (
   .clk(clk), .rst_n(rst_n), .tick(tick), .hit(hit), .flag_clr(flag_clr),
   .match_flag(match_flag), .oc_q(oc_q), .count_down(count_down),
   .count(count), .top_act(top_act)
);

// File: tb/test_pfc_pwm_timer.sv
module test_pfc_pwm_timer;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int WD_LIMIT   = 180000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   clk_sel = 3'd0;
   logic         top_we = 1'b0, cmp_we = 1'b0, mode_we = 1'b0, flag_clr = 1'b0;
   logic [W-1:0] wdata = '0;
   logic         pwm_out, match_flag, count_down;
   logic [W-1:0] count;

   int cyc = 0, checks = 0, errs = 0;

   pfc_pwm_timer i_pfc_pwm_timer (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .top_we(top_we),
      .cmp_we(cmp_we), .mode_we(mode_we), .wdata(wdata), .flag_clr(flag_clr),
      .pwm_out(pwm_out), .match_flag(match_flag), .count(count),
      .count_down(count_down)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_LIMIT) begin
         errs = errs + 1;
         checks = checks + 1;
         $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   function automatic int div_of(input int s);
      case (s)
         1: return 1;
         2: return 8;
         3: return 64;
         4: return 256;
         default: return 1024;
      endcase
   endfunction

   // mode 2 noninv, 3 inv, 5 toggle with compare as TOP
   function automatic int exp_period(input int mode, input int n, input int top, input int c);
      if (mode == 5) return 4 * n * c;
      return 2 * n * top;
   endfunction

   function automatic int exp_high(input int mode, input int n, input int top, input int c);
      if (mode == 5) return 2 * n * c;
      if (mode == 3) return 2 * n * (top - c);
      return 2 * n * c;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         errs = errs + 1;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int which, input int val);
      @(negedge clk);
      wdata = W'(val);
      top_we = (which == 0);
      cmp_we = (which == 1);
      mode_we = (which == 2);
      @(negedge clk);
      top_we = 1'b0; cmp_we = 1'b0; mode_we = 1'b0;
   endtask

   task automatic cfg(input int sel, input int top, input int c, input int mode);
      wr(0, top);
      wr(1, c);
      wr(2, mode);
      clk_sel = 3'(sel);
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic measure(output int per, output int hi);
      int t0, t1;
      while (pwm_out) @(negedge clk);
      while (!pwm_out) @(negedge clk);
      t0 = cyc;
      while (pwm_out) @(negedge clk);
      t1 = cyc;
      while (!pwm_out) @(negedge clk);
      per = cyc - t0;
      hi = t1 - t0;
   endtask

   task automatic run_pwm(input string req, input int sel, input int top, input int c, input int mode);
      int per, hi, n;
      n = div_of(sel);
      cfg(sel, top, c, mode);
      measure(per, hi);
      measure(per, hi);
      chk({req, " period"}, per, exp_period(mode, n, top, c));
      chk({req, " high time"}, hi, exp_high(mode, n, top, c));
   endtask

   task automatic level_hold(input string req, input int lvl, input int span);
      int bad;
      bad = 0;
      for (int i = 0; i < span; i++) begin
         @(negedge clk);
         if (pwm_out !== lvl[0]) bad++;
      end
      chk(req, bad, 0);
   endtask

   initial begin
      void'($urandom(32'd4711));
      wait_cycles(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", int'(count), 0);
      chk("R1 count_down", int'(count_down), 0);
      chk("R1 pwm_out", int'(pwm_out), 0);
      chk("R1 match_flag", int'(match_flag), 0);

      // R3 triangle sequence and direction, N=1, TOP=3
      begin
         int bad, m, ec;
         cfg(1, 3, 1, 2);
         wait_cycles(20);
         while (count != 0) @(negedge clk);
         bad = 0;
         for (int i = 0; i < 12; i++) begin
            m = i % 6;
            ec = (m <= 3) ? m : 6 - m;
            if (int'(count) != ec || count_down !== (m == 0 || m >= 4)) bad++;
            @(negedge clk);
         end
         chk("R3 up/down sequence mismatches", bad, 0);
      end

      // R2 stopped prescaler
      begin
         logic [W-1:0] held;
         clk_sel = 3'd0;
         @(negedge clk);
         held = count;
         wait_cycles(40);
         chk("R2 count held with clk_sel=0", int'(count), int'(held));
      end

      // R4 shadowed compare update: TOP=10, C=4, noninv
      cfg(1, 10, 4, 2);
      wait_cycles(60);
      while (!(count == 8 && count_down)) @(negedge clk);
      wr(1, 7);
      while (!(count == 5 && count_down)) @(negedge clk);
      chk("R4 old compare still active on falling slope", int'(pwm_out), 0);
      while (!(count == 6 && !count_down)) @(negedge clk);
      chk("R4 new compare active after bottom", int'(pwm_out), 1);

      // R10 flag timing (compare now 7)
      while (count != 9) @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk("R10 flag cleared", int'(match_flag), 0);
      while (count != 7) @(negedge clk);
      chk("R10 flag low during matching tick", int'(match_flag), 0);
      @(negedge clk);
      chk("R10 flag set after match", int'(match_flag), 1);
      begin
         int bad;
         bad = 0;
         for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (match_flag !== 1'b1) bad++;
         end
         chk("R10 flag sticky", bad, 0);
      end

      // R7 extremes, TOP=8
      cfg(1, 8, 0, 2); wait_cycles(40); level_hold("R7 noninv C=0 low", 0, 32);
      cfg(1, 8, 8, 2); wait_cycles(40); level_hold("R7 noninv C=TOP high", 1, 32);
      cfg(1, 8, 0, 3); wait_cycles(40); level_hold("R7 inv C=0 high", 1, 32);
      cfg(1, 8, 8, 3); wait_cycles(40); level_hold("R7 inv C=TOP low", 0, 32);

      // R9 disconnected
      cfg(1, 8, 4, 0); wait_cycles(20); level_hold("R9 disconnected low", 0, 40);

      // directed waveforms
      run_pwm("R5 noninv N=1", 1, 10, 3, 2);
      run_pwm("R6 inv N=1", 1, 10, 3, 3);
      run_pwm("R8 toggle 50pct", 1, 0, 6, 5);
      run_pwm("R2 R5 N=256", 4, 3, 2, 2);
      run_pwm("R2 R5 N=1024", 5, 2, 1, 2);

      // constrained random sweep
      for (int it = 0; it < 10; it++) begin
         int sel, top, c, kind, mode;
         sel  = 1 + int'($urandom % 3);
         top  = 3 + int'($urandom % 10);
         c    = 1 + int'($urandom % (top - 1));
         kind = int'($urandom % 3);
         mode = (kind == 0) ? 2 : (kind == 1) ? 3 : 5;
         if (mode == 2)      run_pwm("R5 random noninv", sel, top, c, mode);
         else if (mode == 3) run_pwm("R6 random inv", sel, top, c, mode);
         else                run_pwm("R8 random toggle", sel, top, c, mode);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule